// File: doc/BRIEF.md
# Saturating Event Counter Unit

This block gives a cache controller two identical 32-bit performance counters. Each counter watches one of up to fifteen one-cycle event strobes from the cache, such as read hits, write requests, castouts and prefetch activity. A per-counter configuration register chooses which strobe it watches. A single global enable bit starts and stops both counters together.

Software reaches the block through a simple synchronous register port. Writes commit on the clock edge, and reads return data in the same cycle. Software may preset or clear a counter by writing its value register. When a counter reaches all-ones it stays there and does not wrap. A poller can therefore see that events were lost, rather than getting a silently small value.

A variant parameter selects the extended event set. When it is off, only the nine base event codes can count.

Top module: `evt_mon_unit`

## Requirements
- R1: After reset, the control register, both configuration registers and both value registers all read as zero.
- R2: The register map uses byte addresses as follows.
  - The control register is at 0x00, with the enable in bit 0.
  - Counter n's configuration register is at 0x08 minus 4*n. Its source code is in bits [5:2] and its interrupt-off flag is in bit 0.
  - Counter n's value register is at 0x10 minus 4*n.
  - All other bits read as zero, and a write to the control register changes only its enable bit.
- R3: While the global enable is 0, neither counter changes unless software writes its value.
- R4: A counter whose source code is 0 holds its value.
- R5: For source codes 1 to 9, the counter adds exactly one on each clock edge at which the enable is 1 and event input bit (code-1) is 1.
- R6: With EXT_EVENTS=1, source codes 10 to 15 count event input bits 9 to 14 in the same way.
- R7: With EXT_EVENTS=0, source codes 10 to 15 never make the counter advance.
- R8: A counter at 0xFFFFFFFF stays at 0xFFFFFFFF on further events.
- R9: A software write to a value register loads the written data. If an event for that counter arrives in the same cycle, the written value wins.
- R10: The two counters work independently. Configuring or writing one counter has no effect on the other.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 5 | Byte address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the same cycle during a read |
| evt_in | input | 15 | Event strobes; bit k is event code k+1 |

## Verification
The bench sweeps every source code on both counters of two instances, one with EXT_EVENTS=1 and one with EXT_EVENTS=0. It drives a pseudo-random strobe pattern and counts the expected hits arithmetically.

Several corner cases get targeted checks:
- Saturation: a counter preset just below all-ones must stop at all-ones. A counter that wraps would read a small number instead.
- Write priority: a value write landing on a cycle with an active event must read back exactly the written value. A design that let the increment win would read one more.
- Enable off: holding the enable low with every strobe active must leave both counters unchanged. A design that ignored the enable would read a nonzero count.
- Base variant: the base instance must read zero for codes 10 to 15. A design that leaked the upper codes would read a nonzero count.
- Descending layout: writing one counter and checking that the other still reads its old value catches swapped or aliased addresses.

// File: rtl/evt_mon_pkg.sv
package evt_mon_pkg;
    localparam int DATA_W   = 32;
    localparam int ADDR_W   = 5;
    localparam int SRC_W    = 4;
    localparam int N_CNT    = 2;
    localparam int N_EVT    = (1 << SRC_W) - 1;
    localparam int BASE_EVT = 9;
    localparam int STRIDE   = 4;

    localparam logic [ADDR_W-1:0] CTRL_OFS = 5'h00;
    localparam logic [ADDR_W-1:0] CFG0_OFS = 5'h08;
    localparam logic [ADDR_W-1:0] VAL0_OFS = 5'h10;
    localparam logic [DATA_W-1:0] CNT_MAX  = '1;

    typedef struct packed {
        logic [SRC_W-1:0] src;
        logic             int_off;
    } cnt_cfg_t;

    typedef struct packed {
        logic cfg_we;
        logic val_we;
    } cnt_wr_t;

    // Counter n sits below counter 0 by STRIDE*n bytes.
    function automatic logic [ADDR_W-1:0] cfg_addr(input int n);
        return ADDR_W'(int'(CFG0_OFS) - STRIDE * n);
    endfunction

    function automatic logic [ADDR_W-1:0] val_addr(input int n);
        return ADDR_W'(int'(VAL0_OFS) - STRIDE * n);
    endfunction

    // Source code in bits [5:2], interrupt-off flag in bit 0.
    function automatic logic [DATA_W-1:0] cfg_to_word(input cnt_cfg_t c);
        return {{(DATA_W-SRC_W-2){1'b0}}, c.src, 1'b0, c.int_off};
    endfunction

    function automatic cnt_cfg_t word_to_cfg(input logic [DATA_W-1:0] w);
        cnt_cfg_t c;
        c.src     = w[SRC_W+1:2];
        c.int_off = w[0];
        return c;
    endfunction
endpackage

// File: rtl/evt_mon_srcmux.sv
module evt_mon_srcmux
    import evt_mon_pkg::*;
#(
    parameter bit EXT_EVENTS = 1'b1
) (
    input  logic [N_EVT-1:0] evt_in,
    input  logic [SRC_W-1:0] src,
    output logic             hit
);
    localparam int LIVE_MAX = EXT_EVENTS ? N_EVT : BASE_EVT;

    always_comb begin
        hit = 1'b0;
        for (int k = 1; k <= N_EVT; k++) begin
            if (k <= LIVE_MAX && src == SRC_W'(k))
                hit = evt_in[k-1];
        end
    end
endmodule

// File: rtl/evt_mon_counter.sv
module evt_mon_counter
    import evt_mon_pkg::*;
#(
    parameter bit EXT_EVENTS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              en,
    input  logic [N_EVT-1:0]  evt_in,
    input  cnt_wr_t           wr,
    input  logic [DATA_W-1:0] wdata,
    output cnt_cfg_t          cfg_q,
    output logic [DATA_W-1:0] val_q
);
    logic              hit;
    logic [DATA_W-1:0] val_d;

    evt_mon_srcmux #(.EXT_EVENTS(EXT_EVENTS)) u_mux (
        .evt_in (evt_in),
        .src    (cfg_q.src),
        .hit    (hit)
    );

    always_comb begin
        val_d = val_q;
        if (wr.val_we)
            val_d = wdata;
        else if (en && hit && val_q != CNT_MAX)
            val_d = val_q + 1'b1;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q <= '0;
            val_q <= '0;
        end else begin
            if (wr.cfg_we)
                cfg_q <= word_to_cfg(wdata);
            val_q <= val_d;
        end
    end

    AST_WR_WINS: assert property (@(posedge clk) disable iff (rst)
        wr.val_we |=> val_q == $past(wdata)); // R9
    AST_SAT_HOLD: assert property (@(posedge clk) disable iff (rst)
        (val_q == CNT_MAX && !wr.val_we) |=> val_q == CNT_MAX); // R8
    AST_EN_OFF: assert property (@(posedge clk) disable iff (rst)
        (!en && !wr.val_we) |=> $stable(val_q)); // R3
    AST_SRC_OFF: assert property (@(posedge clk) disable iff (rst)
        (cfg_q.src == '0 && !wr.val_we) |=> $stable(val_q)); // R4
    AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
        !wr.val_we |=> (val_q == $past(val_q) || val_q == $past(val_q) + 1'b1)); // R5

    generate
        if (!EXT_EVENTS) begin : g_base_chk
            AST_BASE_UPPER: assert property (@(posedge clk) disable iff (rst)
                (cfg_q.src > SRC_W'(BASE_EVT) && !wr.val_we) |=> $stable(val_q)); // R7
        end
    endgenerate
endmodule

// File: rtl/evt_mon_regdec.sv
module evt_mon_regdec
    import evt_mon_pkg::*;
(
    input  logic                         bus_sel,
    input  logic                         bus_wr,
    input  logic [ADDR_W-1:0]            bus_addr,
    input  logic                         ctrl_en,
    input  cnt_cfg_t [N_CNT-1:0]         cfg,
    input  logic [N_CNT-1:0][DATA_W-1:0] val,
    output logic                         ctrl_we,
    output cnt_wr_t [N_CNT-1:0]          wr,
    output logic [DATA_W-1:0]            rdata
);
    logic wr_cyc, rd_cyc;

    assign wr_cyc  = bus_sel && bus_wr;
    assign rd_cyc  = bus_sel && !bus_wr;
    assign ctrl_we = wr_cyc && bus_addr == CTRL_OFS;

    generate
        for (genvar n = 0; n < N_CNT; n++) begin : g_dec
            assign wr[n].cfg_we = wr_cyc && bus_addr == cfg_addr(n);
            assign wr[n].val_we = wr_cyc && bus_addr == val_addr(n);
        end
    endgenerate

    always_comb begin
        rdata = '0;
        if (rd_cyc) begin
            if (bus_addr == CTRL_OFS)
                rdata = {{(DATA_W-1){1'b0}}, ctrl_en};
            for (int n = 0; n < N_CNT; n++) begin
                if (bus_addr == cfg_addr(n))
                    rdata = cfg_to_word(cfg[n]);
                if (bus_addr == val_addr(n))
                    rdata = val[n];
            end
        end
    end
endmodule

// File: rtl/evt_mon_unit.sv
module evt_mon_unit
    import evt_mon_pkg::*;
#(
    parameter bit EXT_EVENTS = 1'b1
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic [N_EVT-1:0]  evt_in
);
    logic                         ctrl_en;
    logic                         ctrl_we;
    cnt_wr_t [N_CNT-1:0]          wr;
    cnt_cfg_t [N_CNT-1:0]         cfg;
    logic [N_CNT-1:0][DATA_W-1:0] val;

    evt_mon_regdec u_dec (
        .bus_sel  (bus_sel),
        .bus_wr   (bus_wr),
        .bus_addr (bus_addr),
        .ctrl_en  (ctrl_en),
        .cfg      (cfg),
        .val      (val),
        .ctrl_we  (ctrl_we),
        .wr       (wr),
        .rdata    (bus_rdata)
    );

    always_ff @(posedge clk) begin
        if (rst)
            ctrl_en <= 1'b0;
        else if (ctrl_we)
            ctrl_en <= bus_wdata[0];
    end

    generate
        for (genvar n = 0; n < N_CNT; n++) begin : g_cnt
            evt_mon_counter #(.EXT_EVENTS(EXT_EVENTS)) u_cnt (
                .clk    (clk),
                .rst    (rst),
                .en     (ctrl_en),
                .evt_in (evt_in),
                .wr     (wr[n]),
                .wdata  (bus_wdata),
                .cfg_q  (cfg[n]),
                .val_q  (val[n])
            );
        end
    endgenerate

    AST_CTRL_HOLD: assert property (@(posedge clk) disable iff (rst)
        !ctrl_we |=> $stable(ctrl_en)); // R2
    AST_ONE_TARGET: assert property (@(posedge clk) disable iff (rst)
        $countones({ctrl_we, wr}) <= 1); // R10
endmodule

// File: tb/test_evt_mon_unit.sv
module test_evt_mon_unit;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [14:0] evt_in = '0;
    logic [31:0] rd_ext, rd_base;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    evt_mon_unit #(.EXT_EVENTS(1'b1)) i_evt_mon_unit (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_ext),
        .evt_in(evt_in)
    );

    evt_mon_unit #(.EXT_EVENTS(1'b0)) i_base (
        .clk(clk), .rst(rst), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(rd_base),
        .evt_in(evt_in)
    );

    function automatic logic [4:0] cfg_a(input int n);
        return 5'(8 - 4 * n);
    endfunction
    function automatic logic [4:0] val_a(input int n);
        return 5'(16 - 4 * n);
    endfunction

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] de, output logic [31:0] db);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1;
        de = rd_ext; db = rd_base;
        bus_sel = 1'b0;
    endtask

    task automatic finish_run();
        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual hung expected done");
            finish_run();
        end
    end

    initial begin
        logic [31:0] de, db;
        repeat (3) @(negedge clk);
        rst = 1'b0;

        // R1 reset state
        rd(5'h00, de, db); chk("R1 ctrl", de, 0); chk("R1 ctrl base", db, 0);
        for (int n = 0; n < 2; n++) begin
            rd(cfg_a(n), de, db); chk("R1 cfg", de, 0); chk("R1 cfg base", db, 0);
            rd(val_a(n), de, db); chk("R1 val", de, 0); chk("R1 val base", db, 0);
        end

        // R2 field layout and unused bits
        wr(5'h00, 32'hFFFF_FFFF);
        rd(5'h00, de, db); chk("R2 ctrl bits", de, 32'h1);
        wr(5'h00, 32'h0);
        rd(5'h00, de, db); chk("R2 ctrl clear", de, 32'h0);
        for (int n = 0; n < 2; n++) begin
            wr(cfg_a(n), 32'hFFFF_FFFF);
            rd(cfg_a(n), de, db); chk("R2 cfg bits", de, 32'h3D); chk("R2 cfg bits base", db, 32'h3D);
            wr(cfg_a(n), 32'h0);
        end

        // R5 R6 R7 R10 sweep of every code on every counter
        for (int n = 0; n < 2; n++) begin
            for (int c = 0; c < 16; c++) begin
                int exp_e, exp_b;
                exp_e = 0; exp_b = 0;
                wr(5'h00, 32'h0);
                wr(cfg_a(n), 32'(c << 2));
                wr(cfg_a(1 - n), 32'h0);
                wr(val_a(n), 32'h0);
                wr(val_a(1 - n), 32'h0);
                wr(5'h00, 32'h1);
                for (int k = 0; k < 24; k++) begin
                    logic [14:0] pat;
                    pat = 15'((k * 32'h1F3B) ^ (k << 5) ^ (c * 7));
                    @(negedge clk);
                    evt_in = pat;
                    if (c >= 1 && pat[(c > 0 ? c : 1) - 1]) begin
                        exp_e++;
                        if (c <= 9) exp_b++;
                    end
                end
                @(negedge clk);
                evt_in = '0;
                rd(val_a(n), de, db);
                chk(c == 0 ? "R4 code zero" : (c <= 9 ? "R5 base code" : "R6 ext code"), de, 32'(exp_e));
                chk(c <= 9 ? "R5 base inst" : "R7 base upper", db, 32'(exp_b));
                rd(val_a(1 - n), de, db);
                chk("R10 other counter", de, 0);
                chk("R10 other counter base", db, 0);
            end
        end

        // R3 enable off holds both counters
        wr(cfg_a(0), 32'h4); wr(cfg_a(1), 32'h8);
        wr(val_a(0), 32'd100); wr(val_a(1), 32'd200);
        wr(5'h00, 32'h0);
        @(negedge clk); evt_in = '1;
        repeat (10) @(negedge clk);
        evt_in = '0;
        rd(val_a(0), de, db); chk("R3 ctr0 held", de, 32'd100);
        rd(val_a(1), de, db); chk("R3 ctr1 held", de, 32'd200);

        // R8 saturation
        wr(val_a(1), 32'hFFFF_FFFD);
        wr(5'h00, 32'h1);
        @(negedge clk); evt_in = 15'h0002;
        repeat (6) @(negedge clk);
        evt_in = '0;
        rd(val_a(1), de, db); chk("R8 saturate", de, 32'hFFFF_FFFF); chk("R8 saturate base", db, 32'hFFFF_FFFF);
        rd(val_a(0), de, db); chk("R10 ctr0 untouched", de, 32'd100);

        // R9 write wins over a same-cycle event
        @(negedge clk);
        evt_in = 15'h0001;
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = val_a(0); bus_wdata = 32'd5;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0; evt_in = '0;
        rd(val_a(0), de, db); chk("R9 write wins", de, 32'd5);
        wr(val_a(1), 32'h0);
        rd(val_a(1), de, db); chk("R9 clear to zero", de, 32'h0);

        finish_run();
    end
endmodule